// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit performs the single-cycle bookkeeping that a processor pipeline needs when it takes a synchronous exception or an asynchronous interrupt. The pipeline raises `trap_req` for one cycle and supplies:

- the kind of request;
- the raw code or access type;
- the faulting address;
- the program counter of the trapping instruction;
- the current privilege level;
- the live status word;
- the two delegation masks;
- the two handler base addresses.

On the next clock edge the unit has done four things. It has chosen the handling level, machine or supervisor. It has loaded that level's exception PC, cause and trap-value registers. It has rewritten the status word. It has redirected the program counter and the privilege level.

A request comes in one of three kinds:

- **Explicit code.** Used for illegal instructions, breakpoints, environment calls and interrupts. An environment call is always raised as code 8 and is renamed on entry to match the privilege it came from.
- **Translation fault.** The unit picks a page-fault cause when address translation is on, and an access-fault cause when translation is bare.
- **Misalignment.** The cause follows the access type.

Between traps, every architectural output keeps its value.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset `pc_q` equals parameter RESET_PC, `priv_q` is machine (3), and `mepc_q`, `sepc_q`, `mcause_q`, `scause_q`, `mtval_q`, `stval_q`, `mstatus_q` are all zero. Privilege encoding: user 0, supervisor 1, machine 3.
- R2: In a cycle with `trap_req` low, every output register keeps its value, whatever the other inputs do.
- R3: Kind 0 (explicit code) with `trap_irq` low records `trap_code` as the cause. The exception is code 8, which is recorded as 8 from user, 9 from supervisor and 11 from machine.
- R4: Kind 1 (translation fault) records cause 12/13/15 for access type fetch(0)/load(1)/store(2 or 3) when `xlate_on` is high, and 1/5/7 when it is low.
- R5: Kind 2 (misalignment) records cause 0 for fetch, 4 for load and 6 for store (access 2 or 3). Kind 3 behaves as kind 0.
- R6: Kind 0 with `trap_irq` high records a cause whose bit XLEN-1 is set and whose low bits hold `trap_code`. Delegation for such a cause uses `mideleg`, not `medeleg`.
- R7: A trap is handled in supervisor mode exactly when the current privilege is user or supervisor and bit [cause number] of the selected delegation mask is set. Otherwise it is handled in machine mode.
- R8: On supervisor entry the unit performs these updates:
  - `pc_q` becomes the supervisor base, `priv_q` becomes 1, `scause_q` becomes the cause and `sepc_q` becomes `cur_pc`.
  - In `mstatus_q`, bit 5 takes `mstatus_in[cur_priv]`, bit 8 takes `cur_priv[0]`, bit 1 is cleared, and all other bits come from `mstatus_in`.
  - The machine-level registers are unchanged.
- R9: On machine entry the unit performs these updates:
  - `pc_q` becomes the machine base, `priv_q` becomes 3, `mcause_q` becomes the cause and `mepc_q` becomes `cur_pc`.
  - In `mstatus_q`, bit 7 takes `mstatus_in[cur_priv]`, bits 12:11 take `cur_priv`, bit 3 is cleared, and all other bits come from `mstatus_in`.
  - The supervisor-level registers are unchanged.
- R10: The handling level's trap-value register receives `trap_addr` only for synchronous causes 0, 1, 4, 5, 6, 7, 12, 13 and 15. Otherwise it keeps its value.
- R11: The handler address is the base with its two low bits forced to zero, so `pc_q[1:0]` is 0 after every trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_kind | input | 2 | 0 explicit code, 1 translation fault, 2 misalignment, 3 as 0 |
| trap_irq | input | 1 | Explicit code is an interrupt number |
| trap_code | input | $clog2(XLEN) | Explicit cause or interrupt number |
| trap_acc | input | 2 | Access type: 0 fetch, 1 load, 2/3 store |
| xlate_on | input | 1 | Address translation is active |
| trap_addr | input | XLEN | Faulting address |
| cur_pc | input | XLEN | PC of the trapping instruction |
| cur_priv | input | 2 | Current privilege level |
| mstatus_in | input | XLEN | Live status word |
| medeleg | input | XLEN | Exception delegation mask |
| mideleg | input | XLEN | Interrupt delegation mask |
| mtvec | input | XLEN | Machine handler base |
| stvec | input | XLEN | Supervisor handler base |
| pc_q | output | XLEN | Redirected program counter |
| priv_q | output | 2 | New privilege level |
| mepc_q | output | XLEN | Machine exception PC |
| sepc_q | output | XLEN | Supervisor exception PC |
| mcause_q | output | XLEN | Machine cause |
| scause_q | output | XLEN | Supervisor cause |
| mtval_q | output | XLEN | Machine trap value |
| stval_q | output | XLEN | Supervisor trap value |
| mstatus_q | output | XLEN | Updated status word |

## Verification
The assertions assume that `cur_priv` never carries the reserved value 2 while a trap is requested. The bench only drives 0, 1 and 3 there.

The bench sweeps the following combinations from each legal privilege, under two complementary delegation patterns and with varying status words:

- every explicit code from 0 to 15, plus one high code, both as exception and as interrupt;
- every access type, with translation on and off, for both fault kinds.

Idle cycles with scrambled inputs are interleaved with the traps. The handler bases carry non-zero low bits so that the alignment rule is exercised on every trap.

// File: rtl/trap_pkg.sv
package trap_pkg;

  typedef enum logic [1:0] {
    PRIV_U   = 2'd0,
    PRIV_S   = 2'd1,
    PRIV_RSV = 2'd2,
    PRIV_M   = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    KIND_CODE  = 2'd0,
    KIND_XLATE = 2'd1,
    KIND_MISAL = 2'd2,
    KIND_ALT   = 2'd3
  } kind_e;

  localparam logic [1:0] ACC_FETCH = 2'd0;
  localparam logic [1:0] ACC_LOAD  = 2'd1;

  // status word bit positions (decoded by the CSR file and return logic)
  localparam int ST_SIE  = 1;
  localparam int ST_MIE  = 3;
  localparam int ST_SPIE = 5;
  localparam int ST_MPIE = 7;
  localparam int ST_SPP  = 8;
  localparam int ST_MPP  = 11;

  localparam logic [4:0] C_ECALL_U = 5'd8;
  localparam logic [4:0] C_ECALL_S = 5'd9;
  localparam logic [4:0] C_ECALL_M = 5'd11;

  // set of synchronous causes that carry an address
  localparam logic [15:0] ADDR_CAUSES = 16'b1011_0000_1111_0011;

  function automatic logic [4:0] ecall_for(input logic [1:0] priv);
    case (priv)
      PRIV_U:  return C_ECALL_U;
      PRIV_S:  return C_ECALL_S;
      default: return C_ECALL_M;
    endcase
  endfunction

  function automatic logic [4:0] xlate_cause(input logic [1:0] acc, input logic paged);
    case (acc)
      ACC_FETCH: return paged ? 5'd12 : 5'd1;
      ACC_LOAD:  return paged ? 5'd13 : 5'd5;
      default:   return paged ? 5'd15 : 5'd7;
    endcase
  endfunction

  function automatic logic [4:0] misal_cause(input logic [1:0] acc);
    case (acc)
      ACC_FETCH: return 5'd0;
      ACC_LOAD:  return 5'd4;
      default:   return 5'd6;
    endcase
  endfunction

endpackage

// File: rtl/trap_cause_resolve.sv
module trap_cause_resolve
  import trap_pkg::*;
#(
  parameter int CODE_W = 5
) (
  input  logic [1:0]        kind,
  input  logic              irq,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        acc,
  input  logic              xlate_on,
  input  logic [1:0]        cur_priv,
  output logic [CODE_W-1:0] cause_num,
  output logic              is_irq,
  output logic              tval_wr
);
  localparam int PADW = CODE_W - 5;

  logic [4:0] small_cause;

  always_comb begin
    is_irq      = 1'b0;
    small_cause = 5'd0;
    cause_num   = code;
    case (kind)
      KIND_XLATE: begin
        small_cause = xlate_cause(acc, xlate_on);
        cause_num   = {{PADW{1'b0}}, small_cause};
      end
      KIND_MISAL: begin
        small_cause = misal_cause(acc);
        cause_num   = {{PADW{1'b0}}, small_cause};
      end
      default: begin
        is_irq = irq;
        if (!irq && code == CODE_W'(C_ECALL_U))
          cause_num = {{PADW{1'b0}}, ecall_for(cur_priv)};
      end
    endcase
  end

  always_comb begin
    tval_wr = 1'b0;
    if (!is_irq && cause_num < CODE_W'(16))
      tval_wr = ADDR_CAUSES[cause_num[3:0]];
  end

endmodule

// File: rtl/trap_deleg_select.sv
module trap_deleg_select
  import trap_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int CODE_W = 5
) (
  input  logic [1:0]        cur_priv,
  input  logic              is_irq,
  input  logic [CODE_W-1:0] cause_num,
  input  logic [XLEN-1:0]   medeleg,
  input  logic [XLEN-1:0]   mideleg,
  output logic              to_s
);
  logic [XLEN-1:0] mask;
  logic            low_priv;

  assign mask     = is_irq ? mideleg : medeleg;
  assign low_priv = (cur_priv == PRIV_U) || (cur_priv == PRIV_S);
  assign to_s     = low_priv && mask[cause_num];

endmodule

// File: rtl/trap_status_update.sv
module trap_status_update
  import trap_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] status_in,
  input  logic [1:0]      cur_priv,
  input  logic            to_s,
  output logic [XLEN-1:0] status_nx
);
  logic cur_ie;

  assign cur_ie = status_in[cur_priv];

  always_comb begin
    status_nx = status_in;
    if (to_s) begin
      status_nx[ST_SPIE] = cur_ie;
      status_nx[ST_SPP]  = cur_priv[0];
      status_nx[ST_SIE]  = 1'b0;
    end else begin
      status_nx[ST_MPIE]           = cur_ie;
      status_nx[ST_MPP+1:ST_MPP]   = cur_priv;
      status_nx[ST_MIE]            = 1'b0;
    end
  end

endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trap_req,
  input  logic [1:0]               trap_kind,
  input  logic                     trap_irq,
  input  logic [$clog2(XLEN)-1:0]  trap_code,
  input  logic [1:0]               trap_acc,
  input  logic                     xlate_on,
  input  logic [XLEN-1:0]          trap_addr,
  input  logic [XLEN-1:0]          cur_pc,
  input  logic [1:0]               cur_priv,
  input  logic [XLEN-1:0]          mstatus_in,
  input  logic [XLEN-1:0]          medeleg,
  input  logic [XLEN-1:0]          mideleg,
  input  logic [XLEN-1:0]          mtvec,
  input  logic [XLEN-1:0]          stvec,
  output logic [XLEN-1:0]          pc_q,
  output logic [1:0]               priv_q,
  output logic [XLEN-1:0]          mepc_q,
  output logic [XLEN-1:0]          sepc_q,
  output logic [XLEN-1:0]          mcause_q,
  output logic [XLEN-1:0]          scause_q,
  output logic [XLEN-1:0]          mtval_q,
  output logic [XLEN-1:0]          stval_q,
  output logic [XLEN-1:0]          mstatus_q
);
  localparam int CODE_W = $clog2(XLEN);
  localparam int GAP_W  = XLEN - 1 - CODE_W;

  logic [CODE_W-1:0] cause_num;
  logic              is_irq;
  logic              tval_wr;
  logic              to_s;
  logic [XLEN-1:0]   status_nx;
  logic [XLEN-1:0]   cause_full;
  logic [XLEN-1:0]   target_pc;

  trap_cause_resolve #(.CODE_W(CODE_W)) u_cause (
    .kind      (trap_kind),
    .irq       (trap_irq),
    .code      (trap_code),
    .acc       (trap_acc),
    .xlate_on  (xlate_on),
    .cur_priv  (cur_priv),
    .cause_num (cause_num),
    .is_irq    (is_irq),
    .tval_wr   (tval_wr)
  );

  trap_deleg_select #(.XLEN(XLEN), .CODE_W(CODE_W)) u_deleg (
    .cur_priv  (cur_priv),
    .is_irq    (is_irq),
    .cause_num (cause_num),
    .medeleg   (medeleg),
    .mideleg   (mideleg),
    .to_s      (to_s)
  );

  trap_status_update #(.XLEN(XLEN)) u_status (
    .status_in (mstatus_in),
    .cur_priv  (cur_priv),
    .to_s      (to_s),
    .status_nx (status_nx)
  );

  assign cause_full = {is_irq, {GAP_W{1'b0}}, cause_num};
  assign target_pc  = {(to_s ? stvec[XLEN-1:2] : mtvec[XLEN-1:2]), 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q      <= RESET_PC;
      priv_q    <= PRIV_M;
      mepc_q    <= '0;
      sepc_q    <= '0;
      mcause_q  <= '0;
      scause_q  <= '0;
      mtval_q   <= '0;
      stval_q   <= '0;
      mstatus_q <= '0;
    end else if (trap_req) begin
      pc_q      <= target_pc;
      mstatus_q <= status_nx;
      if (to_s) begin
        priv_q   <= PRIV_S;
        sepc_q   <= cur_pc;
        scause_q <= cause_full;
        if (tval_wr) stval_q <= trap_addr;
      end else begin
        priv_q   <= PRIV_M;
        mepc_q   <= cur_pc;
        mcause_q <= cause_full;
        if (tval_wr) mtval_q <= trap_addr;
      end
    end
  end

endmodule

// File: rtl/trap_entry_checker.sv
module trap_entry_checker #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            trap_req,
  input logic            trap_irq,
  input logic [1:0]      trap_kind,
  input logic [1:0]      cur_priv,
  input logic [XLEN-1:0] cur_pc,
  input logic            to_s,
  input logic [XLEN-1:0] pc_q,
  input logic [1:0]      priv_q,
  input logic [XLEN-1:0] mepc_q,
  input logic [XLEN-1:0] sepc_q,
  input logic [XLEN-1:0] mcause_q,
  input logic [XLEN-1:0] scause_q,
  input logic [XLEN-1:0] mtval_q,
  input logic [XLEN-1:0] stval_q,
  input logic [XLEN-1:0] mstatus_q
);

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !trap_req |=> $stable(pc_q) && $stable(priv_q) && $stable(mepc_q) && $stable(sepc_q)
      && $stable(mcause_q) && $stable(scause_q) && $stable(mtval_q) && $stable(stval_q)
      && $stable(mstatus_q));

  assert_mach_keeps_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && cur_priv == 2'd3 |-> !to_s);

  assert_s_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && to_s |=> priv_q == 2'd1 && !mstatus_q[1] && sepc_q == $past(cur_pc)
      && mstatus_q[8] == $past(cur_priv[0]) && $stable(mepc_q) && $stable(mcause_q));

  assert_m_entry_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && !to_s |=> priv_q == 2'd3 && !mstatus_q[3] && mepc_q == $past(cur_pc)
      && mstatus_q[12:11] == $past(cur_priv) && $stable(sepc_q) && $stable(scause_q));

  assert_irq_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req && trap_irq && trap_kind != 2'd1 && trap_kind != 2'd2 && !to_s
      |=> mcause_q[XLEN-1]);

  assert_aligned_R11: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> pc_q[1:0] == 2'b00);

  assert_legal_priv_R1: assert property (@(posedge clk) disable iff (!rst_n)
    priv_q != 2'd2);

endmodule

bind trap_entry_unit trap_entry_checker #(.XLEN(XLEN)) u_trap_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .trap_req  (trap_req),
  .trap_irq  (trap_irq),
  .trap_kind (trap_kind),
  .cur_priv  (cur_priv),
  .cur_pc    (cur_pc),
  .to_s      (to_s),
  .pc_q      (pc_q),
  .priv_q    (priv_q),
  .mepc_q    (mepc_q),
  .sepc_q    (sepc_q),
  .mcause_q  (mcause_q),
  .scause_q  (scause_q),
  .mtval_q   (mtval_q),
  .stval_q   (stval_q),
  .mstatus_q (mstatus_q)
);

// File: tb/trap_entry_unit_bench.sv
`timescale 1ns/1ps
module trap_entry_unit_bench;
  localparam int XLEN = 32;
  localparam logic [31:0] RST_PC = 32'h0000_1000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_req = 1'b0, trap_irq = 1'b0, xlate_on = 1'b0;
  logic [1:0] trap_kind = '0, trap_acc = '0, cur_priv = '0;
  logic [4:0] trap_code = '0;
  logic [31:0] trap_addr = '0, cur_pc = '0, mstatus_in = '0;
  logic [31:0] medeleg = '0, mideleg = '0;
  logic [31:0] mtvec = 32'h8000_1003, stvec = 32'h4000_2201;
  logic [31:0] pc_q, mepc_q, sepc_q, mcause_q, scause_q, mtval_q, stval_q, mstatus_q;
  logic [1:0]  priv_q;

  int n_cmp = 0, n_bad = 0, step = 0;
  logic [31:0] e_pc, e_mepc, e_sepc, e_mcause, e_scause, e_mtval, e_stval, e_mst;
  logic [1:0]  e_priv;

  always #5 clk = ~clk;

  trap_entry_unit #(.XLEN(XLEN), .RESET_PC(RST_PC)) u_trap_entry_unit (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_kind(trap_kind),
    .trap_irq(trap_irq), .trap_code(trap_code), .trap_acc(trap_acc),
    .xlate_on(xlate_on), .trap_addr(trap_addr), .cur_pc(cur_pc),
    .cur_priv(cur_priv), .mstatus_in(mstatus_in), .medeleg(medeleg),
    .mideleg(mideleg), .mtvec(mtvec), .stvec(stvec), .pc_q(pc_q),
    .priv_q(priv_q), .mepc_q(mepc_q), .sepc_q(sepc_q), .mcause_q(mcause_q),
    .scause_q(scause_q), .mtval_q(mtval_q), .stval_q(stval_q),
    .mstatus_q(mstatus_q)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h (step %0d)", tag, what, act, exp, step);
    end
  endtask

  task automatic chk_all(input string ctag, input string etag);
    chk("R11", "pc", pc_q, e_pc);
    chk("R7", "priv", {30'd0, priv_q}, {30'd0, e_priv});
    chk(etag, "mstatus", mstatus_q, e_mst);
    chk(etag, "mepc", mepc_q, e_mepc);
    chk(etag, "sepc", sepc_q, e_sepc);
    chk(ctag, "mcause", mcause_q, e_mcause);
    chk(ctag, "scause", scause_q, e_scause);
    chk("R10", "mtval", mtval_q, e_mtval);
    chk("R10", "stval", stval_q, e_stval);
  endtask

  // reference: returns expected cause (with interrupt flag) and whether an address is kept
  task automatic ref_cause(input logic [1:0] kind, input logic irq, input logic [4:0] code,
                           input logic [1:0] acc, input logic xl, input logic [1:0] pv,
                           output logic [31:0] cause, output logic addr_kept);
    int c;
    logic flag = 1'b0;
    if (kind == 2'd1) begin
      c = (acc == 2'd0) ? 1 : (acc == 2'd1) ? 5 : 7;
      if (xl) c = (acc == 2'd0) ? 12 : (acc == 2'd1) ? 13 : 15;
    end else if (kind == 2'd2) begin
      c = (acc == 2'd0) ? 0 : (acc == 2'd1) ? 4 : 6;
    end else begin
      c = int'(code);
      flag = irq;
      if (!irq && c == 8) c = (pv == 2'd0) ? 8 : (pv == 2'd1) ? 9 : 11;
    end
    cause = {flag, 26'd0, 5'(c)};
    addr_kept = !flag && (c == 0 || c == 1 || c == 4 || c == 5 || c == 6 || c == 7 ||
                          c == 12 || c == 13 || c == 15);
  endtask

  task automatic do_trap(input logic [1:0] kind, input logic irq, input logic [4:0] code,
                         input logic [1:0] acc, input logic xl, input logic [1:0] pv,
                         input logic [31:0] pat, input string ctag);
    logic [31:0] cause, dmask, mst;
    logic kept, goes_s, ie;
    step++;
    mst = 32'h5A3C_96E1 ^ (32'(step) * 32'h0101_0107);
    trap_req = 1'b1; trap_kind = kind; trap_irq = irq; trap_code = code;
    trap_acc = acc; xlate_on = xl; cur_priv = pv; mstatus_in = mst;
    medeleg = pat; mideleg = ~pat;
    trap_addr = 32'hA500_0000 + 32'(step) * 32'd12;
    cur_pc = 32'h2000_0000 + 32'(step) * 32'd4;
    ref_cause(kind, irq, code, acc, xl, pv, cause, kept);
    dmask = cause[31] ? ~pat : pat;
    goes_s = (pv == 2'd0 || pv == 2'd1) && dmask[cause[4:0]];
    ie = mst[pv];
    e_mst = mst;
    if (goes_s) begin
      e_pc = {stvec[31:2], 2'b00}; e_priv = 2'd1;
      e_sepc = cur_pc; e_scause = cause;
      if (kept) e_stval = trap_addr;
      e_mst[5] = ie; e_mst[8] = pv[0]; e_mst[1] = 1'b0;
    end else begin
      e_pc = {mtvec[31:2], 2'b00}; e_priv = 2'd3;
      e_mepc = cur_pc; e_mcause = cause;
      if (kept) e_mtval = trap_addr;
      e_mst[7] = ie; e_mst[12:11] = pv; e_mst[3] = 1'b0;
    end
    @(posedge clk);
    @(negedge clk);
    trap_req = 1'b0;
    chk_all(ctag, goes_s ? "R8" : "R9");
  endtask

  task automatic idle_cycle();
    step++;
    trap_req = 1'b0; trap_kind = 2'(step); trap_irq = step[0]; trap_code = 5'(step);
    cur_pc = 32'hDEAD_0000 ^ 32'(step); trap_addr = ~cur_pc; mstatus_in = cur_pc;
    cur_priv = 2'd0; medeleg = '1; mideleg = '1;
    @(posedge clk);
    @(negedge clk);
    chk_all("R2", "R2");
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [1:0] privs [3];
    logic [31:0] pats [2];
    privs[0] = 2'd0; privs[1] = 2'd1; privs[2] = 2'd3;
    pats[0] = 32'h0000_B3A5; pats[1] = 32'hFFFF_4C5A;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    e_pc = RST_PC; e_priv = 2'd3; e_mepc = '0; e_sepc = '0; e_mcause = '0;
    e_scause = '0; e_mtval = '0; e_stval = '0; e_mst = '0;
    chk_all("R1", "R1");
    idle_cycle();
    for (int p = 0; p < 3; p++) begin
      for (int d = 0; d < 2; d++) begin
        for (int c = 0; c < 17; c++) begin
          logic [4:0] cd;
          cd = (c == 16) ? 5'd20 : 5'(c);
          do_trap(2'd0, 1'b0, cd, 2'd0, 1'b0, privs[p], pats[d], "R3");
          do_trap(2'd0, 1'b1, cd, 2'd0, 1'b0, privs[p], pats[d], "R6");
          if (c % 5 == 0) idle_cycle();
        end
        do_trap(2'd3, 1'b0, 5'd8, 2'd1, 1'b1, privs[p], pats[d], "R5");
        for (int a = 0; a < 4; a++) begin
          for (int x = 0; x < 2; x++) begin
            do_trap(2'd1, 1'b0, 5'd2, 2'(a), x[0], privs[p], pats[d], "R4");
            do_trap(2'd2, 1'b1, 5'd3, 2'(a), x[0], privs[p], pats[d], "R5");
          end
          idle_cycle();
        end
      end
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule